// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard and Bypass Control

This block holds the dependence-resolution logic for an in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it looks at the instruction in decode (its two source register numbers, how those sources are used, and whether it writes a register or loads from memory). It compares those sources with the destinations of the two instructions ahead of it, which it tracks itself in a small record of the execute and memory stages. From that comparison it raises a stall, or it registers bypass selects that steer the operand and store-data multiplexers when the instruction reaches execute. A store whose data comes from a load immediately ahead gets a late select that is used in the memory stage.

The surrounding pipeline holds the program counter and the fetch/decode register while `stall` is high and presents the same decode instruction again. There is no data stream through the block, so every pin is a plain level signal with no valid/ready handshake. `stall` is combinational from the decode inputs, so it resolves in the same cycle. Every select is registered: it appears in the cycle after the decode instruction advances. Select encoding on all execute-stage selects: 0 = register file value, 1 = result held in EX/MEM, 2 = result held in MEM/WB.

Top module: `hz_ctrl`

## Requirements
- R1: A register-writing non-load instruction directly ahead of the decode instruction, whose destination equals a used source, gives select 1 on that source's execute mux (operand A, operand B or store data) in the next cycle, with no stall.
- R2: A load directly ahead whose destination equals a source used as operand A (ALU operand or base address) or operand B raises `stall` for exactly one cycle. When the held instruction then advances, that source's select is 2.
- R3: A load directly ahead whose destination equals only the store-data source (`id_store` high, `id_use_b` low, no base match) does not stall. `ex_fwd_sd` is 0 in the next cycle and `mem_fwd_sd` is 1 one cycle after that.
- R4: A matching producer two instructions ahead, with no nearer match, gives select 2.
- R5: A matching producer three or more instructions ahead gives select 0, because the register file writes before it reads.
- R6: Register 0 never causes a forward or a stall, either as a source or as a producer's destination.
- R7: In the cycle after a stall the execute-stage selects are all 0 (a bubble), and that bubble forwards nothing to later instructions.
- R8: When both instructions ahead write the same matching register, the nearer one wins (select 1).
- R9: An instruction with `id_wr` low never becomes a bypass source, whatever its `id_rd`.
- R10: A source whose use flag is low gets select 0 and never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_rs1 | input | AW | First source register number |
| id_rs2 | input | AW | Second source register number |
| id_use_a | input | 1 | First source read as ALU operand or base address |
| id_use_b | input | 1 | Second source read as ALU operand |
| id_store | input | 1 | Second source read as store data |
| id_wr | input | 1 | Instruction writes `id_rd` |
| id_load | input | 1 | Instruction is a load |
| id_rd | input | AW | Destination register number |
| stall | output | 1 | Hold PC and fetch/decode, insert bubble |
| ex_fwd_a | output | 2 | Execute operand A select |
| ex_fwd_b | output | 2 | Execute operand B select |
| ex_fwd_sd | output | 2 | Execute store-data select |
| mem_fwd_sd | output | 1 | Memory-stage store data taken from write-back |

## Verification
On every cycle the assertions check these properties: a stall never lasts two cycles in a row, the selects after a stall are a bubble, a late store-data select follows a register-file choice in execute, register 0 and unused sources produce no forwarding, and a decode instruction that reads nothing cannot stall. The bench's directed instruction sequences are needed to show the select values themselves: the distance-one, distance-two and distance-three cases, priority between two producers, producers that write no register, and the one-cycle offset of the late store-data bypass.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [1:0] {
    FW_RF    = 2'd0,
    FW_EXMEM = 2'd1,
    FW_MEMWB = 2'd2
  } fwd_e;
endpackage

// File: rtl/hz_pipe_track.sv
module hz_pipe_track #(
  parameter int AW    = hz_pkg::REG_AW,
  parameter int DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_wr,
  input  logic                    in_ld,
  input  logic [AW-1:0]           in_rd,
  output logic [DEPTH-1:0]        st_wr,
  output logic [DEPTH-1:0][AW-1:0] st_rd,
  output logic                    first_ld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_wr[0] <= 1'b0;
      st_rd[0] <= '0;
      first_ld <= 1'b0;
    end else begin
      st_wr[0] <= in_wr;
      st_rd[0] <= in_rd;
      first_ld <= in_ld;
    end
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_wr[s] <= 1'b0;
        st_rd[s] <= '0;
      end else begin
        st_wr[s] <= st_wr[s-1];
        st_rd[s] <= st_rd[s-1];
      end
    end
  end
endmodule

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          used,
  input  logic [AW-1:0] src,
  input  logic          near_wr,
  input  logic          near_ld,
  input  logic [AW-1:0] near_rd,
  input  logic          far_wr,
  input  logic [AW-1:0] far_rd,
  output fwd_e          sel,
  output logic          ld_hit
);
  logic nz, hit_near, hit_far;

  always_comb begin
    nz       = (src != '0);
    hit_near = used && nz && near_wr && (near_rd == src);
    hit_far  = used && nz && far_wr && (far_rd == src);
    ld_hit   = hit_near && near_ld;
    if (hit_near)     sel = FW_EXMEM;
    else if (hit_far) sel = FW_MEMWB;
    else              sel = FW_RF;
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_a,
  input  logic          id_use_b,
  input  logic          id_store,
  input  logic          id_wr,
  input  logic          id_load,
  input  logic [AW-1:0] id_rd,
  output logic          stall,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic [1:0]    ex_fwd_sd,
  output logic          mem_fwd_sd
);
  localparam int NPATH  = 3;  // operand A, operand B, store data
  localparam int NSTAGE = 2;  // ID/EX and EX/MEM records

  logic [NSTAGE-1:0]         trk_wr;
  logic [NSTAGE-1:0][AW-1:0] trk_rd;
  logic                      trk_ld;

  logic [NPATH-1:0][AW-1:0]  p_src;
  logic [NPATH-1:0]          p_use;
  fwd_e                      p_sel [NPATH];
  logic [NPATH-1:0]          p_ld_hit;

  logic advance, sd_late;
  fwd_e sd_next;
  logic ex_late_q;

  assign p_src[0] = id_rs1;
  assign p_use[0] = id_use_a;
  assign p_src[1] = id_rs2;
  assign p_use[1] = id_use_b;
  assign p_src[2] = id_rs2;
  assign p_use[2] = id_store;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    hz_src_match #(.AW(AW)) u_match (
      .used    (p_use[p]),
      .src     (p_src[p]),
      .near_wr (trk_wr[0]),
      .near_ld (trk_ld),
      .near_rd (trk_rd[0]),
      .far_wr  (trk_wr[1]),
      .far_rd  (trk_rd[1]),
      .sel     (p_sel[p]),
      .ld_hit  (p_ld_hit[p])
    );
  end

  assign stall   = id_valid && (p_ld_hit[0] || p_ld_hit[1]);
  assign advance = id_valid && !stall;
  assign sd_late = p_ld_hit[2];
  assign sd_next = sd_late ? FW_RF : p_sel[2];

  hz_pipe_track #(.AW(AW), .DEPTH(NSTAGE)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_wr    (advance && id_wr && (id_rd != '0)),
    .in_ld    (advance && id_load),
    .in_rd    (id_rd),
    .st_wr    (trk_wr),
    .st_rd    (trk_rd),
    .first_ld (trk_ld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_fwd_a   <= FW_RF;
      ex_fwd_b   <= FW_RF;
      ex_fwd_sd  <= FW_RF;
      ex_late_q  <= 1'b0;
      mem_fwd_sd <= 1'b0;
    end else begin
      if (advance) begin
        ex_fwd_a  <= p_sel[0];
        ex_fwd_b  <= p_sel[1];
        ex_fwd_sd <= sd_next;
        ex_late_q <= sd_late;
      end else begin
        ex_fwd_a  <= FW_RF;
        ex_fwd_b  <= FW_RF;
        ex_fwd_sd <= FW_RF;
        ex_late_q <= 1'b0;
      end
      mem_fwd_sd <= ex_late_q;
    end
  end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int AW = hz_pkg::REG_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          id_valid,
  input logic [AW-1:0] id_rs1,
  input logic          id_use_a,
  input logic          id_use_b,
  input logic          stall,
  input logic [1:0]    ex_fwd_a,
  input logic [1:0]    ex_fwd_b,
  input logic [1:0]    ex_fwd_sd,
  input logic          mem_fwd_sd
);
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R2

  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ex_fwd_a == 2'd0 && ex_fwd_b == 2'd0 && ex_fwd_sd == 2'd0)); // R7

  AST_LATE_SD_AFTER_RF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fwd_sd |-> ($past(ex_fwd_sd) == 2'd0)); // R3

  AST_ZERO_REG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !stall && id_rs1 == '0) |=> (ex_fwd_a == 2'd0)); // R6

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !stall && !id_use_a) |=> (ex_fwd_a == 2'd0)); // R10

  AST_NO_READ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_use_a && !id_use_b) |-> !stall); // R3
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid   (id_valid),
  .id_rs1     (id_rs1),
  .id_use_a   (id_use_a),
  .id_use_b   (id_use_b),
  .stall      (stall),
  .ex_fwd_a   (ex_fwd_a),
  .ex_fwd_b   (ex_fwd_b),
  .ex_fwd_sd  (ex_fwd_sd),
  .mem_fwd_sd (mem_fwd_sd)
);

// File: tb/sim_hz_ctrl.sv
`timescale 1ns/1ps
module sim_hz_ctrl;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid = 1'b0, id_use_a = 1'b0, id_use_b = 1'b0, id_store = 1'b0;
  logic id_wr = 1'b0, id_load = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic stall, mem_fwd_sd;
  logic [1:0] ex_fwd_a, ex_fwd_b, ex_fwd_sd;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic s_stall, s_mem;
  logic [1:0] s_a, s_b, s_sd;

  always #10 clk = ~clk;

  hz_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_a(id_use_a), .id_use_b(id_use_b), .id_store(id_store), .id_wr(id_wr),
    .id_load(id_load), .id_rd(id_rd), .stall(stall), .ex_fwd_a(ex_fwd_a),
    .ex_fwd_b(ex_fwd_b), .ex_fwd_sd(ex_fwd_sd), .mem_fwd_sd(mem_fwd_sd)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one decode slot: drive at negedge, sample stall, then sample EX outputs after the edge
  task automatic step(input logic v, input logic [AW-1:0] rs1, input logic [AW-1:0] rs2,
                      input logic ua, input logic ub, input logic st,
                      input logic wr, input logic ld, input logic [AW-1:0] rd);
    @(negedge clk);
    id_valid = v; id_rs1 = rs1; id_rs2 = rs2; id_use_a = ua; id_use_b = ub;
    id_store = st; id_wr = wr; id_load = ld; id_rd = rd;
    #1 s_stall = stall;
    @(posedge clk);
    #1;
    s_a = ex_fwd_a; s_b = ex_fwd_b; s_sd = ex_fwd_sd; s_mem = mem_fwd_sd;
  endtask

  task automatic nop();
    step(1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic flush();
    repeat (3) nop();
  endtask

  task automatic alu(input logic [AW-1:0] rd);
    step(1'b1, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, rd);
  endtask

  task automatic ldi(input logic [AW-1:0] rd);
    step(1'b1, 5'd2, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, rd);
  endtask

  task automatic t_reset();
    chk("R7 reset stall", stall, 0);
    chk("R7 reset fwd_a", ex_fwd_a, 0);
    chk("R7 reset fwd_b", ex_fwd_b, 0);
    chk("R3 reset mem_fwd_sd", mem_fwd_sd, 0);
  endtask

  task automatic t_dist1();
    flush();
    alu(5'd3);
    step(1'b1, 5'd3, 5'd9, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd10);
    chk("R1 dist1 stall", s_stall, 0);
    chk("R1 dist1 fwd_a", s_a, 1);
    chk("R10 dist1 fwd_b unmatched", s_b, 0);
    flush();
    alu(5'd8);
    step(1'b1, 5'd1, 5'd8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0);
    chk("R1 dist1 store data", s_sd, 1);
  endtask

  task automatic t_dist2_3();
    flush();
    alu(5'd4);
    alu(5'd11);
    step(1'b1, 5'd1, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd12);
    chk("R4 dist2 fwd_b", s_b, 2);
    flush();
    alu(5'd4);
    alu(5'd11);
    alu(5'd13);
    step(1'b1, 5'd4, 5'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd12);
    chk("R5 dist3 fwd_a", s_a, 0);
  endtask

  task automatic t_load_use();
    flush();
    ldi(5'd5);
    step(1'b1, 5'd5, 5'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd14);
    chk("R2 load-use stall", s_stall, 1);
    chk("R7 bubble fwd_a", s_a, 0);
    step(1'b1, 5'd5, 5'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd14);
    chk("R2 released stall", s_stall, 0);
    chk("R2 after stall fwd_a", s_a, 2);
    nop();
    chk("R7 bubble forwards nothing", s_a, 0);
    flush();
    ldi(5'd15);
    step(1'b1, 5'd15, 5'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0);
    chk("R2 load into base stall", s_stall, 1);
  endtask

  task automatic t_load_store();
    flush();
    ldi(5'd6);
    step(1'b1, 5'd1, 5'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0);
    chk("R3 store data no stall", s_stall, 0);
    chk("R3 ex store sel", s_sd, 0);
    chk("R3 mem not yet", s_mem, 0);
    nop();
    chk("R3 mem late select", s_mem, 1);
    nop();
    chk("R3 mem one cycle", s_mem, 0);
  endtask

  task automatic t_reg0();
    flush();
    alu(5'd0);
    step(1'b1, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd7);
    chk("R6 r0 fwd_a", s_a, 0);
    chk("R6 r0 fwd_b", s_b, 0);
    flush();
    ldi(5'd0);
    step(1'b1, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd7);
    chk("R6 r0 load no stall", s_stall, 0);
  endtask

  task automatic t_priority();
    flush();
    alu(5'd7);
    alu(5'd7);
    step(1'b1, 5'd7, 5'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd16);
    chk("R8 nearest fwd_a", s_a, 1);
    chk("R8 nearest fwd_b", s_b, 1);
  endtask

  task automatic t_nowrite();
    flush();
    step(1'b1, 5'd1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd9);
    step(1'b1, 5'd9, 5'd9, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd17);
    chk("R9 no-write fwd_a", s_a, 0);
    chk("R9 no-write fwd_b", s_b, 0);
  endtask

  task automatic t_unused();
    flush();
    alu(5'd18);
    step(1'b1, 5'd18, 5'd18, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd19);
    chk("R10 unused fwd_a", s_a, 0);
    chk("R10 unused fwd_b", s_b, 0);
    flush();
    ldi(5'd20);
    step(1'b1, 5'd20, 5'd20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd19);
    chk("R10 unused no stall", s_stall, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_dist1();
    t_dist2_3();
    t_load_use();
    t_load_store();
    t_reg0();
    t_priority();
    t_nowrite();
    t_unused();
    flush();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule